// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This unit turns eight general-purpose input pins into interrupt requests. Every pin passes through a two-flop synchronizer. Each pin is then judged by its own configuration: it can follow a level (high or low), catch one edge direction (rising or falling), or catch any edge. Edge events are held in a sticky status bit until software clears it by writing a one. Level conditions are reported live for as long as they last.

Software reaches the unit through a simple byte-wide memory-mapped port. Three configuration registers choose the detection mode of each pin. An enable register gates the pins into the interrupt. Two status views are readable: unmasked and masked. A write-one-to-clear register acknowledges edge events. The interrupt line may be shared with other units, so a single registered output is raised whenever any enabled pin has a pending condition.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the mode, both-edges, polarity and enable registers read 0, the interrupt output is 0, and the clear register (0x41C) always reads 0.
- R2: With its mode bit (register 0x404) at 1 a pin is level-sensitive. Its unmasked status bit equals the synchronized pin when its polarity bit (0x40C) is 1, and the inverted pin when the polarity bit is 0.
- R3: With its mode bit at 0 and both-edges bit (0x408) at 0, a pin latches a status bit on a rising edge when its polarity bit is 1, and on a falling edge when it is 0.
- R4: With its mode bit at 0 and both-edges bit at 1, a pin latches on either edge, and its polarity bit has no effect.
- R5: A latched edge bit stays set until a 1 is written to that bit of the clear register. Writing 0 to a bit leaves it unchanged.
- R6: A level-sensitive status bit cannot be cleared while its level persists.
- R7: When a new edge arrives in the same cycle as a clear of that bit, the bit remains set.
- R8: The masked status (0x418) reads as the unmasked status (0x414) ANDed with the enable register (0x410).
- R9: The interrupt output is the OR of all masked status bits, delayed by one register.
- R10: The configuration registers at 0x404, 0x408, 0x40C and 0x410 read back what was written. Read data appears on the cycle after the read strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous GPIO inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets an edge that lands in the same cycle as its own clear. A design that gives the clear priority would lose that event and read 0 where 1 is expected. It also writes zeros to the clear register, which a design that treats any write as a clear would wrongly empty. It tries to clear an active level, which a design that latches levels would drop. It sets the polarity bits on both-edge pins to each value in turn, so a design that lets polarity leak into dual-edge detection would miss one direction. Finally, it samples the interrupt in the cycle just after the enable changes, which exposes an output driven combinationally instead of through one register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int OFS_W = 12;

  localparam logic [OFS_W-1:0] OFS_MODE  = 12'h404;
  localparam logic [OFS_W-1:0] OFS_DUAL  = 12'h408;
  localparam logic [OFS_W-1:0] OFS_POL   = 12'h40C;
  localparam logic [OFS_W-1:0] OFS_EN    = 12'h410;
  localparam logic [OFS_W-1:0] OFS_RAW   = 12'h414;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h418;
  localparam logic [OFS_W-1:0] OFS_CLR   = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_DUAL,
    SEL_POL,
    SEL_EN,
    SEL_RAW,
    SEL_MASK,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_MODE: s = SEL_MODE;
      OFS_DUAL: s = SEL_DUAL;
      OFS_POL:  s = SEL_POL;
      OFS_EN:   s = SEL_EN;
      OFS_RAW:  s = SEL_RAW;
      OFS_MASK: s = SEL_MASK;
      OFS_CLR:  s = SEL_CLR;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] cfg_level,
  input  logic [W-1:0] cfg_dual,
  input  logic [W-1:0] cfg_pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);

  logic [W-1:0] pin_d;

  always_ff @(posedge clk) begin
    if (rst) pin_d <= '0;
    else     pin_d <= pin_s;
  end

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic rise, fall, evt, lat_q;

    assign rise = pin_s[g] & ~pin_d[g];
    assign fall = ~pin_s[g] & pin_d[g];
    assign evt  = ~cfg_level[g] &
                  (cfg_dual[g] ? (rise | fall) : (cfg_pol[g] ? rise : fall));

    // New event takes priority over a simultaneous clear.
    always_ff @(posedge clk) begin
      if (rst)               lat_q <= 1'b0;
      else if (cfg_level[g]) lat_q <= 1'b0;
      else                   lat_q <= evt | (lat_q & ~clr[g]);
    end

    assign raw[g] = cfg_level[g] ? ~(pin_s[g] ^ cfg_pol[g]) : lat_q;

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (lat_q && !clr[g] && !cfg_level[g]) |=> lat_q)
      else $error("edge status lost without clear");

    p_edge_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !evt && !cfg_level[g]) |=> !lat_q)
      else $error("edge status survived a clear");

    p_new_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (evt && clr[g]) |=> lat_q)
      else $error("simultaneous clear dropped new edge");
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [W-1:0]     bus_wdata,
  input  logic [W-1:0]     raw,
  input  logic [W-1:0]     masked,
  output logic [W-1:0]     cfg_level,
  output logic [W-1:0]     cfg_dual,
  output logic [W-1:0]     cfg_pol,
  output logic [W-1:0]     cfg_en,
  output logic [W-1:0]     clr,
  output logic [W-1:0]     rdata
);

  reg_sel_e sel;
  logic     wr_stb, rd_stb;

  assign sel    = bus_sel ? decode_ofs(bus_addr) : SEL_NONE;
  assign wr_stb = bus_sel & bus_we;
  assign rd_stb = bus_sel & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_level <= '0;
      cfg_dual  <= '0;
      cfg_pol   <= '0;
      cfg_en    <= '0;
    end else if (wr_stb) begin
      case (sel)
        SEL_MODE: cfg_level <= bus_wdata;
        SEL_DUAL: cfg_dual  <= bus_wdata;
        SEL_POL:  cfg_pol   <= bus_wdata;
        SEL_EN:   cfg_en    <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_stb && sel == SEL_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_stb) begin
      case (sel)
        SEL_MODE: rdata <= cfg_level;
        SEL_DUAL: rdata <= cfg_dual;
        SEL_POL:  rdata <= cfg_pol;
        SEL_EN:   rdata <= cfg_en;
        SEL_RAW:  rdata <= raw;
        SEL_MASK: rdata <= masked;
        default:  rdata <= '0;
      endcase
    end
  end

  p_clear_reads_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == OFS_CLR) |=> (rdata == '0))
    else $error("clear register read nonzero");

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> $stable(rdata))
    else $error("read data changed without a read");

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);

  logic [NPINS-1:0] pin_s, raw, masked;
  logic [NPINS-1:0] cfg_level, cfg_dual, cfg_pol, cfg_en, clr;
  logic             irq_q;

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_i),
    .q   (pin_s)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_s     (pin_s),
    .cfg_level (cfg_level),
    .cfg_dual  (cfg_dual),
    .cfg_pol   (cfg_pol),
    .clr       (clr),
    .raw       (raw)
  );

  gpio_irq_regs #(.W(NPINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw       (raw),
    .masked    (masked),
    .cfg_level (cfg_level),
    .cfg_dual  (cfg_dual),
    .cfg_pol   (cfg_pol),
    .cfg_en    (cfg_en),
    .clr       (clr),
    .rdata     (bus_rdata)
  );

  assign masked = raw & cfg_en;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end

  assign irq_o = irq_q;

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (|masked) |=> irq_o)
    else $error("pending masked status did not raise interrupt");

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !(|masked) |=> !irq_o)
    else $error("interrupt raised with nothing pending");

endmodule

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;
  import gpio_irq_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin_i = '0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_unit #(.NPINS(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {mode, dual, pol, en, pins_before, pins_after, exp_raw, exp_masked}
  localparam logic [63:0] VEC [8] = '{
    64'hFF_00_FF_0F_00_A5_A5_05,
    64'hFF_00_00_FF_00_A5_5A_5A,
    64'h00_00_FF_FF_0F_3C_30_30,
    64'h00_00_00_F0_0F_3C_03_00,
    64'h00_FF_00_FF_0F_3C_33_33,
    64'h00_FF_FF_01_0F_3C_33_01,
    64'h0F_30_C5_FF_00_F3_F9_F9,
    64'hFF_00_FF_00_00_FF_FF_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=hang expected=finish");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    rd(OFS_MODE, v); chk("R1 mode reset", v, 8'h00);
    rd(OFS_DUAL, v); chk("R1 dual reset", v, 8'h00);
    rd(OFS_POL,  v); chk("R1 pol reset", v, 8'h00);
    rd(OFS_EN,   v); chk("R1 enable reset", v, 8'h00);
    rd(OFS_CLR,  v); chk("R1 clear reads zero", v, 8'h00);

    // R10 readback
    wr(OFS_MODE, 8'h5A); wr(OFS_DUAL, 8'hC3); wr(OFS_POL, 8'h96); wr(OFS_EN, 8'h3C);
    rd(OFS_MODE, v); chk("R10 mode readback", v, 8'h5A);
    rd(OFS_DUAL, v); chk("R10 dual readback", v, 8'hC3);
    rd(OFS_POL,  v); chk("R10 pol readback", v, 8'h96);
    rd(OFS_EN,   v); chk("R10 enable readback", v, 8'h3C);
    repeat (3) @(negedge clk);
    chk("R10 rdata held", bus_rdata, 8'h3C);

    // Vector table: R2 R3 R4 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [63:0] e;
      e = VEC[i];
      wr(OFS_MODE, e[63:56]); wr(OFS_DUAL, e[55:48]);
      wr(OFS_POL, e[47:40]);  wr(OFS_EN, e[39:32]);
      @(negedge clk); pin_i = e[31:24];
      settle();
      wr(OFS_CLR, 8'hFF);
      @(negedge clk); pin_i = e[23:16];
      settle();
      rd(OFS_RAW, v);  chk($sformatf("R2 R3 R4 raw vec%0d", i), v, e[15:8]);
      rd(OFS_MASK, v); chk($sformatf("R8 masked vec%0d", i), v, e[7:0]);
      chk($sformatf("R9 irq vec%0d", i), {7'b0, irq_o}, {7'b0, |e[7:0]});
    end

    // R5 write-one-to-clear, zeros ignored
    wr(OFS_MODE, 8'h00); wr(OFS_DUAL, 8'h00); wr(OFS_POL, 8'hFF); wr(OFS_EN, 8'hFF);
    @(negedge clk); pin_i = 8'h00; settle();
    wr(OFS_CLR, 8'hFF);
    @(negedge clk); pin_i = 8'h0F; settle();
    rd(OFS_RAW, v); chk("R5 edges latched", v, 8'h0F);
    wr(OFS_CLR, 8'h00);
    rd(OFS_RAW, v); chk("R5 zero write no effect", v, 8'h0F);
    wr(OFS_CLR, 8'h01);
    rd(OFS_RAW, v); chk("R5 clear bit0 only", v, 8'h0E);
    rd(OFS_CLR, v); chk("R1 clear reads zero after use", v, 8'h00);

    // R6 level not clearable
    wr(OFS_MODE, 8'hFF); wr(OFS_POL, 8'hFF);
    settle();
    wr(OFS_CLR, 8'hFF);
    rd(OFS_RAW, v); chk("R6 level survives clear", v, 8'h0F);

    // R7 edge and clear in the same cycle
    wr(OFS_MODE, 8'h00); wr(OFS_DUAL, 8'h01); wr(OFS_POL, 8'h00); wr(OFS_EN, 8'h01);
    @(negedge clk); pin_i = 8'h00; settle();
    wr(OFS_CLR, 8'hFF);
    @(negedge clk); pin_i = 8'h01; settle();
    rd(OFS_RAW, v); chk("R4 dual rise with pol 0", v, 8'h01);
    @(negedge clk); pin_i = 8'h00;
    @(posedge clk); @(posedge clk);
    wr(OFS_CLR, 8'h01);
    rd(OFS_RAW, v); chk("R7 new edge beats clear", v, 8'h01);
    wr(OFS_CLR, 8'h01);
    rd(OFS_RAW, v); chk("R5 later clear works", v, 8'h00);

    // R9 one-cycle latency on the interrupt
    wr(OFS_MODE, 8'hFF); wr(OFS_POL, 8'hFF); wr(OFS_EN, 8'h00);
    @(negedge clk); pin_i = 8'hFF; settle();
    chk("R9 irq low while disabled", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = OFS_EN; bus_wdata = 8'h80;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R9 irq not yet", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    chk("R9 irq one cycle later", {7'b0, irq_o}, 8'h01);
    @(negedge clk); pin_i = 8'h7F;
    repeat (2) @(negedge clk);
    chk("R9 irq still up before level drops", {7'b0, irq_o}, 8'h01);
    @(negedge clk);
    chk("R9 irq drops after level", {7'b0, irq_o}, 8'h00);

    finish_run();
  end

endmodule